// File: doc/BRIEF.md
# Queue Doorbell Decoder and Ring Pointer Tracker

This block sits on the register side of a queue-based accelerator. Software sends work and returns completion credits by writing a single 64-bit doorbell word. The block splits each doorbell into its fields and checks it. It then moves the addressed queue pair's submission tail or completion head. Doorbells that fail any check are discarded, and a sticky error flag records that something was discarded.

The same block keeps, for each queue, the consumed position of the submission ring. It also keeps the completion-ring write slot and a producer phase bit. The accelerator side advances the consumed position with a pop strobe and reports finished requests with a completion strobe. For each finished request the block emits one completion descriptor. Bit 0 of the descriptor's last word carries the current phase, and the phase inverts every time the completion write slot wraps. Software can therefore tell fresh entries from stale ones without reading a separate valid register.

A status port selects one queue and shows all of its pointers, its phase and its pending-submission count. A free-running counter of accepted doorbells sits beside the status port.

Top module: `qdb_tracker`

## Requirements
- R1: Doorbell fields: queue number in bits [11:0], command in [15:12], check byte in [23:16], ring index in [47:32], priority in [63:48]. An accepted command 0 loads the queue's submission tail with the index, and an accepted command 1 loads its completion head. The new value is visible on the status port in the cycle after the write.
- R2: A doorbell whose check byte is not 0x5A is dropped (no pointer or counter change) and sets the error flag.
- R3: A doorbell is also dropped, and sets the error flag, if any of these holds: the queue number is NUM_Q or more, the command is neither 0 nor 1, or the index is DEPTH or more.
- R4: Once set, the error flag stays at 1 until reset.
- R5: `db_count` rises by exactly one for each accepted doorbell, and holds otherwise.
- R6: The priority field and bits [31:24] have no effect: a doorbell with them non-zero behaves exactly like the same doorbell with them zero.
- R7: `stat_pending` equals (submission tail − consumed position) modulo DEPTH for the selected queue.
- R8: A pop advances the queue's consumed position by one and wraps from DEPTH−1 to 0. A pop while the pending count is 0 is ignored.
- R9: A completion strobe for queue q produces, one cycle later, a single-cycle `cqe_valid` with `cqe_qn`=q and `cqe_slot` equal to q's completion write slot. `cqe_word` carries the phase in bit 0 and q's consumed position (before any same-cycle pop) from bit 16 upward.
- R10: Each completion advances the queue's write slot with wrap at DEPTH−1. The phase inverts whenever the slot wraps to 0.
- R11: After reset all pointers, the error flag, the counter and `cqe_valid` are 0, and every queue's phase is 1.
- R12: An operation on one queue leaves the pointers and phase of every other queue unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| db_valid | input | 1 | Doorbell write strobe |
| db_data | input | 64 | Doorbell word |
| sq_pop | input | 1 | Accelerator consumed one submission |
| sq_pop_qn | input | QSEL_W | Queue of the pop |
| cpl_valid | input | 1 | Accelerator finished one request |
| cpl_qn | input | QSEL_W | Queue of the completion |
| cqe_valid | output | 1 | Completion descriptor valid (one cycle) |
| cqe_qn | output | QSEL_W | Queue of the descriptor |
| cqe_slot | output | IDX_W | Completion ring slot to be written |
| cqe_word | output | 32 | Descriptor last word: phase in bit 0, consumed position from bit 16 |
| err_flag | output | 1 | Sticky dropped-doorbell flag |
| db_count | output | CNT_W | Accepted doorbell count |
| stat_qn | input | QSEL_W | Queue selected for status |
| stat_sq_tail | output | IDX_W | Submission tail |
| stat_sq_head | output | IDX_W | Submission consumed position |
| stat_cq_head | output | IDX_W | Completion head from software |
| stat_cq_wr | output | IDX_W | Completion write slot |
| stat_phase | output | 1 | Producer phase |
| stat_pending | output | IDX_W | Pending submissions |

## Verification
The bench goes after the ring wraps. If the phase inverted on the wrong completion, the ninth descriptor on an eight-slot ring would carry phase 1 again. If the consumed position skipped its wrap, it would run past DEPTH−1. A pending count computed without the modulo step would show a huge value once the tail has wrapped behind the head. A pop on an empty ring that is not ignored would push the consumed position past the tail. The bench also sends doorbells with a corrupt check byte, an out-of-range queue, an unknown command and an oversized index. A design that let any of these through would change a pointer or the counter, and one that lost the sticky flag would clear the error after the next good write.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  // Doorbell field layout (software depends on these positions)
  localparam int QN_LSB   = 0;
  localparam int QN_BITS  = 12;
  localparam int CMD_LSB  = 12;
  localparam int CMD_BITS = 4;
  localparam int CHK_LSB  = 16;
  localparam int CHK_BITS = 8;
  localparam int IDX_LSB  = 32;
  localparam int IDX_BITS = 16;

  localparam logic [CHK_BITS-1:0] DB_CHECK_BYTE = 8'h5A;

  // Completion descriptor last word
  localparam int CQE_W         = 32;
  localparam int CQE_PHASE_BIT = 0;
  localparam int CQE_SQH_LSB   = 16;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_SQ_TAIL = 4'd0,
    CMD_CQ_HEAD = 4'd1
  } db_cmd_e;

  typedef struct packed {
    logic [QN_BITS-1:0]  qn;
    logic [CMD_BITS-1:0] cmd;
    logic [CHK_BITS-1:0] chk;
    logic [IDX_BITS-1:0] idx;
  } db_fields_t;
endpackage

// File: rtl/qdb_decode.sv
module qdb_decode
  import qdb_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             db_valid,
  input  logic [63:0]      db_data,
  output logic             acc_sq,
  output logic             acc_cq,
  output logic             reject,
  output logic [NUM_Q-1:0] qsel,
  output logic [IDX_W-1:0] idx
);
  localparam logic [QN_BITS-1:0]  QN_LIM  = QN_BITS'(NUM_Q);
  localparam logic [IDX_BITS-1:0] IDX_LIM = IDX_BITS'(DEPTH);

  db_fields_t f;
  logic       chk_ok;
  logic       qn_ok;
  logic       idx_ok;
  logic       is_sq;
  logic       is_cq;
  logic       all_ok;
  logic       unused_db_bits;

  always_comb begin
    f.qn  = db_data[QN_LSB  +: QN_BITS];
    f.cmd = db_data[CMD_LSB +: CMD_BITS];
    f.chk = db_data[CHK_LSB +: CHK_BITS];
    f.idx = db_data[IDX_LSB +: IDX_BITS];
  end

  // priority and reserved byte carry no meaning here
  assign unused_db_bits = ^{db_data[63:48], db_data[31:24]};

  always_comb begin
    chk_ok = (f.chk == DB_CHECK_BYTE);
    qn_ok  = (f.qn < QN_LIM);
    idx_ok = (f.idx < IDX_LIM);
    is_sq  = (f.cmd == CMD_SQ_TAIL);
    is_cq  = (f.cmd == CMD_CQ_HEAD);
    all_ok = chk_ok && qn_ok && idx_ok && (is_sq || is_cq);
    acc_sq = db_valid && all_ok && is_sq;
    acc_cq = db_valid && all_ok && is_cq;
    reject = db_valid && !all_ok;
    idx    = f.idx[IDX_W-1:0];
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_qsel
    assign qsel[i] = (f.qn == QN_BITS'(i));
  end
endmodule

// File: rtl/qdb_qptr.sv
module qdb_qptr #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tail_wr,
  input  logic             chead_wr,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             pop_req,
  input  logic             cpl_req,
  output logic [IDX_W-1:0] sq_tail,
  output logic [IDX_W-1:0] sq_head,
  output logic [IDX_W-1:0] cq_head,
  output logic [IDX_W-1:0] cq_wr,
  output logic             phase,
  output logic [IDX_W-1:0] pending
);
  localparam logic [IDX_W-1:0] LAST    = IDX_W'(DEPTH - 1);
  localparam logic [IDX_W:0]   DEPTH_X = (IDX_W + 1)'(DEPTH);

  logic [IDX_W-1:0] sq_tail_q, sq_tail_d;
  logic [IDX_W-1:0] sq_head_q, sq_head_d;
  logic [IDX_W-1:0] cq_head_q, cq_head_d;
  logic [IDX_W-1:0] cq_wr_q, cq_wr_d;
  logic             phase_q, phase_d;
  logic [IDX_W:0]   diff;
  logic             pop_ok;
  logic             sq_head_en;
  logic             cq_wr_en;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    diff = {1'b0, sq_tail_q} - {1'b0, sq_head_q};
    if (sq_tail_q < sq_head_q) diff = diff + DEPTH_X;
  end
  assign pending = diff[IDX_W-1:0];

  assign pop_ok     = pop_req && (pending != '0);
  assign sq_head_en = pop_ok;
  assign cq_wr_en   = cpl_req;

  always_comb begin
    sq_tail_d = tail_wr  ? wr_idx : sq_tail_q;
    cq_head_d = chead_wr ? wr_idx : cq_head_q;
    sq_head_d = step(sq_head_q);
    cq_wr_d   = step(cq_wr_q);
    phase_d   = (cq_wr_q == LAST) ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_tail_q <= '0;
      cq_head_q <= '0;
    end else begin
      sq_tail_q <= sq_tail_d;
      cq_head_q <= cq_head_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_head_q <= '0;
    end else if (sq_head_en) begin
      sq_head_q <= sq_head_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cq_wr_q <= '0;
      phase_q <= 1'b1;
    end else if (cq_wr_en) begin
      cq_wr_q <= cq_wr_d;
      phase_q <= phase_d;
    end
  end

  assign sq_tail = sq_tail_q;
  assign sq_head = sq_head_q;
  assign cq_head = cq_head_q;
  assign cq_wr   = cq_wr_q;
  assign phase   = phase_q;
endmodule

// File: rtl/qdb_cqe_reg.sv
module qdb_cqe_reg
  import qdb_pkg::*;
#(
  parameter int QSEL_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [QSEL_W-1:0] qn_in,
  input  logic [IDX_W-1:0]  slot_in,
  input  logic              phase_in,
  input  logic [IDX_W-1:0]  sqh_in,
  output logic              cqe_valid,
  output logic [QSEL_W-1:0] cqe_qn,
  output logic [IDX_W-1:0]  cqe_slot,
  output logic [CQE_W-1:0]  cqe_word
);
  logic              valid_q;
  logic [QSEL_W-1:0] qn_q;
  logic [IDX_W-1:0]  slot_q;
  logic [CQE_W-1:0]  word_q, word_d;

  always_comb begin
    word_d                          = '0;
    word_d[CQE_PHASE_BIT]           = phase_in;
    word_d[CQE_SQH_LSB +: IDX_W]    = sqh_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qn_q   <= '0;
      slot_q <= '0;
      word_q <= '0;
    end else if (load) begin
      qn_q   <= qn_in;
      slot_q <= slot_in;
      word_q <= word_d;
    end
  end

  assign cqe_valid = valid_q;
  assign cqe_qn    = qn_q;
  assign cqe_slot  = slot_q;
  assign cqe_word  = word_q;
endmodule

// File: rtl/qdb_tracker.sv
module qdb_tracker
  import qdb_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int DEPTH = 8,
  parameter int CNT_W = 16,
  localparam int QSEL_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1,
  localparam int IDX_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              db_valid,
  input  logic [63:0]       db_data,
  input  logic              sq_pop,
  input  logic [QSEL_W-1:0] sq_pop_qn,
  input  logic              cpl_valid,
  input  logic [QSEL_W-1:0] cpl_qn,
  output logic              cqe_valid,
  output logic [QSEL_W-1:0] cqe_qn,
  output logic [IDX_W-1:0]  cqe_slot,
  output logic [31:0]       cqe_word,
  output logic              err_flag,
  output logic [CNT_W-1:0]  db_count,
  input  logic [QSEL_W-1:0] stat_qn,
  output logic [IDX_W-1:0]  stat_sq_tail,
  output logic [IDX_W-1:0]  stat_sq_head,
  output logic [IDX_W-1:0]  stat_cq_head,
  output logic [IDX_W-1:0]  stat_cq_wr,
  output logic              stat_phase,
  output logic [IDX_W-1:0]  stat_pending
);
  localparam int QSLOTS = 1 << QSEL_W;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // doorbell decode
  logic             acc_sq, acc_cq, reject;
  logic [NUM_Q-1:0] qsel;
  logic [IDX_W-1:0] db_idx;

  qdb_decode #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_dec (
    .db_valid (db_valid),
    .db_data  (db_data),
    .acc_sq   (acc_sq),
    .acc_cq   (acc_cq),
    .reject   (reject),
    .qsel     (qsel),
    .idx      (db_idx)
  );

  // per-queue state
  logic [IDX_W-1:0] tail_a [QSLOTS];
  logic [IDX_W-1:0] head_a [QSLOTS];
  logic [IDX_W-1:0] chd_a  [QSLOTS];
  logic [IDX_W-1:0] cwr_a  [QSLOTS];
  logic [IDX_W-1:0] pend_a [QSLOTS];
  logic             ph_a   [QSLOTS];
  logic [QSLOTS-1:0] q_live;

  for (genvar i = 0; i < QSLOTS; i++) begin : g_q
    if (i < NUM_Q) begin : g_live
      assign q_live[i] = 1'b1;
      qdb_qptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_core_n),
        .tail_wr  (acc_sq && qsel[i]),
        .chead_wr (acc_cq && qsel[i]),
        .wr_idx   (db_idx),
        .pop_req  (sq_pop && (sq_pop_qn == QSEL_W'(i))),
        .cpl_req  (cpl_valid && (cpl_qn == QSEL_W'(i))),
        .sq_tail  (tail_a[i]),
        .sq_head  (head_a[i]),
        .cq_head  (chd_a[i]),
        .cq_wr    (cwr_a[i]),
        .phase    (ph_a[i]),
        .pending  (pend_a[i])
      );
    end else begin : g_pad
      assign q_live[i] = 1'b0;
      assign tail_a[i] = '0;
      assign head_a[i] = '0;
      assign chd_a[i]  = '0;
      assign cwr_a[i]  = '0;
      assign ph_a[i]   = 1'b0;
      assign pend_a[i] = '0;
    end
  end

  // completion descriptor
  logic cpl_ok;
  assign cpl_ok = cpl_valid && q_live[cpl_qn];

  qdb_cqe_reg #(.QSEL_W(QSEL_W), .IDX_W(IDX_W)) u_cqe (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .load      (cpl_ok),
    .qn_in     (cpl_qn),
    .slot_in   (cwr_a[cpl_qn]),
    .phase_in  (ph_a[cpl_qn]),
    .sqh_in    (head_a[cpl_qn]),
    .cqe_valid (cqe_valid),
    .cqe_qn    (cqe_qn),
    .cqe_slot  (cqe_slot),
    .cqe_word  (cqe_word)
  );

  // accepted-doorbell counter and sticky error
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             err_q, err_d;

  assign cnt_en = acc_sq || acc_cq;
  assign cnt_d  = cnt_q + 1'b1;
  assign err_d  = err_q || reject;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign db_count = cnt_q;
  assign err_flag = err_q;

  // status read
  assign stat_sq_tail = tail_a[stat_qn];
  assign stat_sq_head = head_a[stat_qn];
  assign stat_cq_head = chd_a[stat_qn];
  assign stat_cq_wr   = cwr_a[stat_qn];
  assign stat_phase   = ph_a[stat_qn];
  assign stat_pending = pend_a[stat_qn];
endmodule

// File: rtl/qdb_tracker_checker.sv
module qdb_tracker_checker #(
  parameter int NUM_Q  = 4,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 16,
  parameter int QSEL_W = 2,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              db_valid,
  input logic [63:0]       db_data,
  input logic              cpl_valid,
  input logic [QSEL_W-1:0] cpl_qn,
  input logic              cqe_valid,
  input logic              err_flag,
  input logic [CNT_W-1:0]  db_count,
  input logic [IDX_W-1:0]  stat_pending
);
  localparam logic [11:0]      QN_LIM   = 12'(NUM_Q);
  localparam logic [IDX_W:0]   DEPTH_X  = (IDX_W + 1)'(DEPTH);

  assert_bad_check_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && db_data[23:16] != 8'h5A) |=> (err_flag && db_count == $past(db_count)));

  assert_bad_queue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_valid && db_data[11:0] >= QN_LIM) |=> err_flag);

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    db_valid |=> (db_count == $past(db_count) || db_count == $past(db_count) + 1'b1));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !db_valid |=> $stable(db_count));

  assert_pending_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, stat_pending} < DEPTH_X);

  assert_cqe_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && int'(cpl_qn) < NUM_Q) |=> cqe_valid);

  assert_cqe_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cpl_valid |=> !cqe_valid);
endmodule

bind qdb_tracker qdb_tracker_checker #(
  .NUM_Q(NUM_Q), .DEPTH(DEPTH), .CNT_W(CNT_W), .QSEL_W(QSEL_W), .IDX_W(IDX_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .db_valid     (db_valid),
  .db_data      (db_data),
  .cpl_valid    (cpl_valid),
  .cpl_qn       (cpl_qn),
  .cqe_valid    (cqe_valid),
  .err_flag     (err_flag),
  .db_count     (db_count),
  .stat_pending (stat_pending)
);

// File: tb/qdb_tracker_test.sv
module qdb_tracker_test;
  localparam int NUM_Q = 4;
  localparam int DEPTH = 8;
  localparam int CNT_W = 16;
  localparam int QSEL_W = 2;
  localparam int IDX_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              db_valid;
  logic [63:0]       db_data;
  logic              sq_pop;
  logic [QSEL_W-1:0] sq_pop_qn;
  logic              cpl_valid;
  logic [QSEL_W-1:0] cpl_qn;
  logic              cqe_valid;
  logic [QSEL_W-1:0] cqe_qn;
  logic [IDX_W-1:0]  cqe_slot;
  logic [31:0]       cqe_word;
  logic              err_flag;
  logic [CNT_W-1:0]  db_count;
  logic [QSEL_W-1:0] stat_qn;
  logic [IDX_W-1:0]  stat_sq_tail, stat_sq_head, stat_cq_head, stat_cq_wr, stat_pending;
  logic              stat_phase;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt  = 0;

  always #10 clk = ~clk;  // 50 MHz

  qdb_tracker #(.NUM_Q(NUM_Q), .DEPTH(DEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_data(db_data),
    .sq_pop(sq_pop), .sq_pop_qn(sq_pop_qn), .cpl_valid(cpl_valid), .cpl_qn(cpl_qn),
    .cqe_valid(cqe_valid), .cqe_qn(cqe_qn), .cqe_slot(cqe_slot), .cqe_word(cqe_word),
    .err_flag(err_flag), .db_count(db_count), .stat_qn(stat_qn),
    .stat_sq_tail(stat_sq_tail), .stat_sq_head(stat_sq_head), .stat_cq_head(stat_cq_head),
    .stat_cq_wr(stat_cq_wr), .stat_phase(stat_phase), .stat_pending(stat_pending)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    db_valid = 0; db_data = '0; sq_pop = 0; sq_pop_qn = '0;
    cpl_valid = 0; cpl_qn = '0; stat_qn = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    exp_cnt = 0;
  endtask

  function automatic logic [63:0] mk_db(input int qn, input int cmd, input int chk,
                                        input int idx, input int prio);
    return {16'(prio), 16'(idx), 8'h00, 8'(chk), 4'(cmd), 12'(qn)};
  endfunction

  task automatic ring(input logic [63:0] w);
    @(negedge clk);
    db_valid = 1; db_data = w;
    @(negedge clk);
    db_valid = 0; db_data = '0;
  endtask

  task automatic pop(input int qn);
    @(negedge clk);
    sq_pop = 1; sq_pop_qn = QSEL_W'(qn);
    @(negedge clk);
    sq_pop = 0;
  endtask

  task automatic peek(input int qn);
    stat_qn = QSEL_W'(qn);
    #1;
  endtask

  task automatic t_reset_state();
    do_reset();
    for (int q = 0; q < NUM_Q; q++) begin
      peek(q);
      check("R11", "tail", int'(stat_sq_tail), 0);
      check("R11", "head", int'(stat_sq_head), 0);
      check("R11", "cq_wr", int'(stat_cq_wr), 0);
      check("R11", "phase", int'(stat_phase), 1);
    end
    check("R11", "err", int'(err_flag), 0);
    check("R11", "count", int'(db_count), 0);
    check("R11", "cqe_valid", int'(cqe_valid), 0);
  endtask

  task automatic t_good_doorbells();
    ring(mk_db(1, 0, 8'h5A, 6, 0)); exp_cnt++;
    peek(1);
    check("R1", "sq tail q1", int'(stat_sq_tail), 6);
    ring(mk_db(3, 1, 8'h5A, 4, 0)); exp_cnt++;
    peek(3);
    check("R1", "cq head q3", int'(stat_cq_head), 4);
    check("R1", "sq tail q3 untouched", int'(stat_sq_tail), 0);
    check("R5", "count", int'(db_count), exp_cnt);
    peek(0);
    check("R12", "q0 tail", int'(stat_sq_tail), 0);
    check("R12", "q0 cq head", int'(stat_cq_head), 0);
    check("R2", "no error on good", int'(err_flag), 0);
  endtask

  task automatic t_priority_ignored();
    ring(mk_db(2, 0, 8'h5A, 7, 16'hFFFF) | 64'h0000_0000_FF00_0000); exp_cnt++;
    peek(2);
    check("R6", "tail with prio", int'(stat_sq_tail), 7);
    check("R6", "count with prio", int'(db_count), exp_cnt);
    check("R6", "no error with prio", int'(err_flag), 0);
  endtask

  task automatic t_pop_pending();
    do_reset();
    ring(mk_db(2, 0, 8'h5A, 5, 0));
    peek(2);
    check("R7", "pending 5", int'(stat_pending), 5);
    for (int k = 0; k < 3; k++) pop(2);
    peek(2);
    check("R8", "head 3", int'(stat_sq_head), 3);
    check("R7", "pending 2", int'(stat_pending), 2);
    ring(mk_db(2, 0, 8'h5A, 1, 0));
    peek(2);
    check("R7", "pending wrapped", int'(stat_pending), 6);
    for (int k = 0; k < 6; k++) pop(2);
    peek(2);
    check("R8", "head wrapped", int'(stat_sq_head), 1);
    check("R7", "pending empty", int'(stat_pending), 0);
    pop(2);
    peek(2);
    check("R8", "pop on empty ignored", int'(stat_sq_head), 1);
    peek(0);
    check("R12", "q0 head", int'(stat_sq_head), 0);
  endtask

  task automatic t_completions();
    // q2 consumed position is 1 from the previous scenario
    for (int k = 0; k < DEPTH + 1; k++) begin
      @(negedge clk);
      cpl_valid = 1; cpl_qn = 2'd2;
      @(negedge clk);
      cpl_valid = 0;
      check("R9", "cqe_valid", int'(cqe_valid), 1);
      check("R9", "cqe_qn", int'(cqe_qn), 2);
      check("R10", "slot", int'(cqe_slot), k % DEPTH);
      check("R10", "phase bit", int'(cqe_word[0]), (k < DEPTH) ? 1 : 0);
      check("R9", "sq head in cqe", int'(cqe_word[16 +: IDX_W]), 1);
      @(negedge clk);
      check("R9", "cqe single cycle", int'(cqe_valid), 0);
    end
    peek(2);
    check("R10", "phase after wrap", int'(stat_phase), 0);
    check("R10", "cq_wr after wrap", int'(stat_cq_wr), 1);
    peek(1);
    check("R12", "q1 phase", int'(stat_phase), 1);
    check("R12", "q1 cq_wr", int'(stat_cq_wr), 0);
  endtask

  task automatic t_bad_check();
    do_reset();
    ring(mk_db(0, 0, 8'hA5, 3, 0));
    peek(0);
    check("R2", "tail unchanged", int'(stat_sq_tail), 0);
    check("R2", "count unchanged", int'(db_count), 0);
    check("R2", "error set", int'(err_flag), 1);
    ring(mk_db(0, 0, 8'h5A, 3, 0));
    peek(0);
    check("R4", "error sticky", int'(err_flag), 1);
    check("R5", "count after good", int'(db_count), 1);
  endtask

  task automatic t_bad_fields();
    do_reset();
    ring(mk_db(NUM_Q, 0, 8'h5A, 2, 0));
    check("R3", "bad queue err", int'(err_flag), 1);
    do_reset();
    ring(mk_db(1, 2, 8'h5A, 2, 0));
    peek(1);
    check("R3", "bad cmd err", int'(err_flag), 1);
    check("R3", "bad cmd tail", int'(stat_sq_tail), 0);
    check("R3", "bad cmd cq head", int'(stat_cq_head), 0);
    do_reset();
    ring(mk_db(1, 0, 8'h5A, DEPTH, 0));
    peek(1);
    check("R3", "bad idx err", int'(err_flag), 1);
    check("R3", "bad idx tail", int'(stat_sq_tail), 0);
    check("R3", "bad count", int'(db_count), 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_good_doorbells();
    t_priority_ignored();
    t_pop_pending();
    t_completions();
    t_bad_check();
    t_bad_fields();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule